// File: doc/BRIEF.md
# Position-Ordered Power Rail Sequencer

This block drives the enable pins of a set of power rails (six by default) when a board powers up and powers down. A shared position counter walks through numbered sequence slots. Each rail is assigned a slot for the up direction and a slot for the down direction. When the counter reaches a rail's slot, that rail's enable changes after its own programmed delay. The counter moves on only when every rail in the current slot has finished and its monitor reports the expected level: good on the way up, discharged on the way down. A rail with up slot 0 takes no part in sequencing, and its enable follows a direct control bit.

The run request combines an ON pin, which has selectable polarity and can be masked, with a software run bit, which also has a mask. A discharge-required option keeps the sequence from starting while any sequenced rail is still charged. Optional per-rail timeout windows detect a rail that fails to reach its threshold. Such a rail raises a sticky up or down fault and stalls the sequence. A breakpoint can freeze the counter at a chosen slot during power-up. A two-bit status output and the live counter value show progress. A tick-enable input sets the time base for all delays and windows.

Top module: `rail_sequencer`

## Requirements
- R1: The run request is true when (on_mask=0 or on_pin XOR on_active_low = 1) and (sw_mask=0 or sw_run=1). The request is registered once. From status 0, a true request starts power-up.
- R2: The status output encodes 0 = off (sequence down done), 1 = powering up, 2 = powering down, 3 = on (sequence up done). While the status is 0 the position count is 0, and power-up begins with the count at 1.
- R3: During power-up, a sequenced rail is enabled only while the count equals its up slot. The count advances by one in the cycle after every rail at the current slot has its enable high and its good input high.
- R4: With tick held high, a sequenced rail's enable rises up_delay+1 cycles after the count reaches its up slot, and falls down_delay+1 cycles after it becomes active in power-down. Delays count tick-enabled cycles only.
- R5: A rail whose up slot is 0 has its enable follow its direct bit one cycle later, in every state.
- R6: When discharge_required=1, power-up does not start while any rail with a non-zero up slot reports not discharged. Rails with up slot 0 are not considered.
- R7: When the request drops in status 3, the count loads the highest down slot among sequenced rails and counts down to 0. At count c, every sequenced rail whose down slot is at least c turns off. The count steps down once all of those rails are off and discharged. After count 0 is finished, the status becomes 0.
- R8: When the request drops during power-up, power-down starts from the current count and follows the rule of R7.
- R9: While bp_enable=1 during power-up and the count equals bp_position, the count holds. The bp_match output is 1 whenever the count equals bp_position, whatever the value of bp_enable.
- R10: For a 3-bit up timeout code k, the window is 0 (no limit) when k=0, and otherwise UP_BASE*4^(k-1) ticks. The window runs while the rail is enabled and not good. A rail that exhausts its window sets up_fault, which stays set until the next power-up starts, and the count holds.
- R11: The down timeout works like R10, using DN_BASE, and runs while the rail is disabled and not discharged. It sets down_fault, which is cleared only when the next power-up starts.
- R12: Power-up ends, with status 3 and the count kept, in the cycle after the rails at the slot equal to the highest up slot are done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable for delays and windows |
| on_pin | input | 1 | ON request pin |
| on_active_low | input | 1 | 1 makes the ON pin active low |
| on_mask | input | 1 | 1 makes the ON pin required |
| sw_run | input | 1 | Software run bit |
| sw_mask | input | 1 | 1 makes the software bit required |
| discharge_required | input | 1 | Block power-up until sequenced rails are discharged |
| up_slot | input | NCH*POS_W | Per-rail up slot, 0 = not sequenced |
| dn_slot | input | NCH*POS_W | Per-rail down slot |
| direct_en | input | NCH | Enable value for rails with up slot 0 |
| up_delay | input | NCH*DLY_W | Per-rail turn-on delay in ticks |
| dn_delay | input | NCH*DLY_W | Per-rail turn-off delay in ticks |
| up_tmo_code | input | NCH*3 | Per-rail up window code |
| dn_tmo_code | input | NCH*3 | Per-rail down window code |
| rail_good | input | NCH | Rail above its good threshold |
| rail_discharged | input | NCH | Rail below its discharge threshold |
| bp_enable | input | 1 | Breakpoint enable |
| bp_position | input | POS_W | Breakpoint slot |
| rail_en | output | NCH | Rail enables |
| seq_status | output | 2 | Sequencer status |
| pos_count | output | POS_W | Current position count |
| bp_match | output | 1 | Count equals bp_position |
| up_fault | output | 1 | Sticky up timeout fault |
| down_fault | output | 1 | Sticky down timeout fault |

## Verification
The bench builds the block with UP_BASE=4 and DN_BASE=8 ticks. With these small bases, a code-1 window expires within a few cycles and both timeout faults can be observed next to their exact cycle boundaries. The widths keep their defaults (six rails, 10-bit slots, 13-bit delays), so the slot compares and the catch-up rule for down slots run at full size. Small delays and an always-high tick make the up_delay+1 edge timing and the slot-advance spacing observable cycle by cycle.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_UPRUN = 2'd1,
    ST_DNRUN = 2'd2,
    ST_ON    = 2'd3
  } seq_st_e;

  // window length in ticks: 0 = unlimited, else base * 4^(code-1)
  function automatic logic [31:0] tmo_ticks(input logic [2:0] code, input logic [31:0] base);
    logic [31:0] r;
    if (code == 3'd0) r = 32'd0;
    else r = base << (2 * (32'(code) - 32'd1));
    return r;
  endfunction
endpackage

// File: rtl/rseq_trig.sv
module rseq_trig (
  input  logic clk,
  input  logic rst,
  input  logic on_pin,
  input  logic on_active_low,
  input  logic on_mask,
  input  logic sw_run,
  input  logic sw_mask,
  output logic run_q
);
  logic pin_ok, sw_ok;
  assign pin_ok = !on_mask || (on_pin ^ on_active_low);
  assign sw_ok  = !sw_mask || sw_run;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= pin_ok && sw_ok;
  end

  // R1: a masked-out pair can never hold the request low
  assert_unmasked_run_R1: assert property (@(posedge clk) disable iff (rst)
    (!on_mask && !sw_mask) |=> run_q);
endmodule

// File: rtl/rseq_chan.sv
module rseq_chan #(
  parameter int DLY_W = 13,
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             seq_in,
  input  logic             direct_en,
  input  logic             act_up,
  input  logic             act_dn,
  input  logic             step_chg,
  input  logic [DLY_W-1:0] up_dly,
  input  logic [DLY_W-1:0] dn_dly,
  input  logic [TMO_W-1:0] up_lim,
  input  logic [TMO_W-1:0] dn_lim,
  input  logic             good,
  input  logic             dis,
  output logic             en,
  output logic             up_done,
  output logic             dn_done,
  output logic             up_to,
  output logic             dn_to
);
  logic [DLY_W-1:0] dcnt;
  logic [TMO_W-1:0] tcnt;
  logic up_wait, dn_wait;

  assign up_done = en && good;
  assign dn_done = !en && dis;
  assign up_wait = seq_in && !step_chg && act_up && en && !good && (up_lim != '0);
  assign dn_wait = seq_in && !step_chg && act_dn && !en && !dis && (dn_lim != '0);
  assign up_to   = up_wait && tick && (tcnt == up_lim - TMO_W'(1));
  assign dn_to   = dn_wait && tick && (tcnt == dn_lim - TMO_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      dcnt <= '0;
      tcnt <= '0;
    end else if (!seq_in) begin
      en   <= direct_en;
      dcnt <= '0;
      tcnt <= '0;
    end else if (step_chg) begin
      dcnt <= '0;
      tcnt <= '0;
    end else if (act_up) begin
      if (!en) begin
        if (dcnt == up_dly) en <= 1'b1;
        else if (tick)      dcnt <= dcnt + DLY_W'(1);
      end else if (up_wait && tick && tcnt != up_lim) begin
        tcnt <= tcnt + TMO_W'(1);
      end
    end else if (act_dn) begin
      if (en) begin
        if (dcnt == dn_dly) en <= 1'b0;
        else if (tick)      dcnt <= dcnt + DLY_W'(1);
      end else if (dn_wait && tick && tcnt != dn_lim) begin
        tcnt <= tcnt + TMO_W'(1);
      end
    end
  end

  assert_direct_follow_R5: assert property (@(posedge clk) disable iff (rst)
    !seq_in |=> (en == $past(direct_en)));
  assert_rise_in_slot_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> $past(!seq_in || act_up));
  assert_fall_in_slot_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(en) |-> $past(!seq_in || act_dn));
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             dis_ok,
  input  logic             up_step_done,
  input  logic             dn_step_done,
  input  logic [POS_W-1:0] max_up,
  input  logic [POS_W-1:0] max_dn,
  input  logic             bp_enable,
  input  logic [POS_W-1:0] bp_position,
  input  logic             up_to_any,
  input  logic             dn_to_any,
  output seq_st_e          st,
  output logic [POS_W-1:0] pos,
  output logic             step_chg,
  output logic             bp_match,
  output logic             up_fault,
  output logic             down_fault
);
  seq_st_e          st_n;
  logic [POS_W-1:0] pos_n;
  logic             start;

  assign bp_match = (pos == bp_position);

  always_comb begin
    st_n  = st;
    pos_n = pos;
    case (st)
      ST_OFF: if (run && dis_ok) begin
        st_n  = ST_UPRUN;
        pos_n = POS_W'(1);
      end
      ST_UPRUN: begin
        if (!run) st_n = ST_DNRUN;
        else if (up_step_done && !(bp_enable && bp_match)) begin
          if (pos >= max_up) st_n = ST_ON;
          else pos_n = pos + POS_W'(1);
        end
      end
      ST_ON: if (!run) begin
        st_n  = ST_DNRUN;
        pos_n = max_dn;
      end
      default: if (dn_step_done) begin
        if (pos == '0) st_n = ST_OFF;
        else pos_n = pos - POS_W'(1);
      end
    endcase
  end

  assign step_chg = (st_n != st) || (pos_n != pos);
  assign start    = (st == ST_OFF) && (st_n == ST_UPRUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_OFF;
      pos        <= '0;
      up_fault   <= 1'b0;
      down_fault <= 1'b0;
    end else begin
      st  <= st_n;
      pos <= pos_n;
      if (start)          up_fault <= 1'b0;
      else if (up_to_any) up_fault <= 1'b1;
      if (start)          down_fault <= 1'b0;
      else if (dn_to_any) down_fault <= 1'b1;
    end
  end

  assert_off_pos_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF) |-> (pos == '0));
  assert_discharge_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF && !dis_ok) |=> (st == ST_OFF));
  assert_bp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_UPRUN && bp_enable && bp_match) |=> $stable(pos));
  assert_down_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DNRUN && !dn_step_done) |=> ($stable(pos) && st == ST_DNRUN));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int NCH     = 6,
  parameter int POS_W   = 10,
  parameter int DLY_W   = 13,
  parameter int TMO_W   = 24,
  parameter int UP_BASE = 16,
  parameter int DN_BASE = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 on_pin,
  input  logic                 on_active_low,
  input  logic                 on_mask,
  input  logic                 sw_run,
  input  logic                 sw_mask,
  input  logic                 discharge_required,
  input  logic [NCH*POS_W-1:0] up_slot,
  input  logic [NCH*POS_W-1:0] dn_slot,
  input  logic [NCH-1:0]       direct_en,
  input  logic [NCH*DLY_W-1:0] up_delay,
  input  logic [NCH*DLY_W-1:0] dn_delay,
  input  logic [NCH*3-1:0]     up_tmo_code,
  input  logic [NCH*3-1:0]     dn_tmo_code,
  input  logic [NCH-1:0]       rail_good,
  input  logic [NCH-1:0]       rail_discharged,
  input  logic                 bp_enable,
  input  logic [POS_W-1:0]     bp_position,
  output logic [NCH-1:0]       rail_en,
  output logic [1:0]           seq_status,
  output logic [POS_W-1:0]     pos_count,
  output logic                 bp_match,
  output logic                 up_fault,
  output logic                 down_fault
);
  seq_st_e          st;
  logic             run_q, step_chg, dis_ok;
  logic [NCH-1:0]   seq, act_up, act_dn, up_done, dn_done, up_to, dn_to;
  logic [POS_W-1:0] max_up, max_dn;

  rseq_trig u_trig (
    .clk(clk), .rst(rst), .on_pin(on_pin), .on_active_low(on_active_low),
    .on_mask(on_mask), .sw_run(sw_run), .sw_mask(sw_mask), .run_q(run_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [POS_W-1:0] us, ds;
    logic [TMO_W-1:0] ul, dl;
    assign us = up_slot[i*POS_W +: POS_W];
    assign ds = dn_slot[i*POS_W +: POS_W];
    assign ul = TMO_W'(tmo_ticks(up_tmo_code[i*3 +: 3], 32'(UP_BASE)));
    assign dl = TMO_W'(tmo_ticks(dn_tmo_code[i*3 +: 3], 32'(DN_BASE)));
    assign seq[i]    = (us != '0);
    assign act_up[i] = seq[i] && (st == ST_UPRUN) && (us == pos_count);
    assign act_dn[i] = seq[i] && (st == ST_DNRUN) && (ds >= pos_count);

    rseq_chan #(.DLY_W(DLY_W), .TMO_W(TMO_W)) u_chan (
      .clk(clk), .rst(rst), .tick(tick), .seq_in(seq[i]), .direct_en(direct_en[i]),
      .act_up(act_up[i]), .act_dn(act_dn[i]), .step_chg(step_chg),
      .up_dly(up_delay[i*DLY_W +: DLY_W]), .dn_dly(dn_delay[i*DLY_W +: DLY_W]),
      .up_lim(ul), .dn_lim(dl), .good(rail_good[i]), .dis(rail_discharged[i]),
      .en(rail_en[i]), .up_done(up_done[i]), .dn_done(dn_done[i]),
      .up_to(up_to[i]), .dn_to(dn_to[i])
    );
  end

  always_comb begin
    max_up = '0;
    max_dn = '0;
    for (int i = 0; i < NCH; i++) begin
      if (seq[i] && up_slot[i*POS_W +: POS_W] > max_up) max_up = up_slot[i*POS_W +: POS_W];
      if (seq[i] && dn_slot[i*POS_W +: POS_W] > max_dn) max_dn = dn_slot[i*POS_W +: POS_W];
    end
  end

  assign dis_ok = !discharge_required || (&(rail_discharged | ~seq));

  rseq_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst(rst), .run(run_q), .dis_ok(dis_ok),
    .up_step_done(&(up_done | ~act_up)), .dn_step_done(&(dn_done | ~act_dn)),
    .max_up(max_up), .max_dn(max_dn), .bp_enable(bp_enable), .bp_position(bp_position),
    .up_to_any(|up_to), .dn_to_any(|dn_to), .st(st), .pos(pos_count),
    .step_chg(step_chg), .bp_match(bp_match), .up_fault(up_fault), .down_fault(down_fault)
  );

  assign seq_status = st;
endmodule

// File: tb/rail_sequencer_tb_top.sv
module rail_sequencer_tb_top;
  localparam int NCH = 6, POS_W = 10, DLY_W = 13, TMO_W = 24;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b1;
  logic on_pin = 0, on_active_low = 0, on_mask = 0, sw_run = 0, sw_mask = 1, dis_req = 0;
  logic bp_en = 0;
  logic [POS_W-1:0] bp_pos = 10'd9;
  logic [NCH-1:0] direct = '0, good_kill = '0, dis_kill = '0;
  logic [POS_W-1:0] upp[NCH], dnp[NCH];
  logic [DLY_W-1:0] udl[NCH], ddl[NCH];
  logic [2:0] utc[NCH], dtc[NCH];
  logic [NCH*POS_W-1:0] up_slot, dn_slot;
  logic [NCH*DLY_W-1:0] up_delay, dn_delay;
  logic [NCH*3-1:0] up_tc, dn_tc;
  logic [NCH-1:0] rail_en, rail_good, rail_dis;
  logic [1:0] st;
  logic [POS_W-1:0] pos;
  logic bp_match, up_fault, down_fault;

  int checks = 0, errors = 0, cyc = 0;
  int rise[NCH], fall[NCH], pos_arr[16], dn_start;
  logic [NCH-1:0] en_prev = '0;
  logic [1:0] st_prev = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      up_slot[i*POS_W +: POS_W] = upp[i];
      dn_slot[i*POS_W +: POS_W] = dnp[i];
      up_delay[i*DLY_W +: DLY_W] = udl[i];
      dn_delay[i*DLY_W +: DLY_W] = ddl[i];
      up_tc[i*3 +: 3] = utc[i];
      dn_tc[i*3 +: 3] = dtc[i];
    end
  end
  assign rail_good = rail_en & ~good_kill;
  assign rail_dis  = ~rail_en & ~dis_kill;

  rail_sequencer #(.NCH(NCH), .POS_W(POS_W), .DLY_W(DLY_W), .TMO_W(TMO_W),
                   .UP_BASE(4), .DN_BASE(8)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .on_pin(on_pin), .on_active_low(on_active_low),
    .on_mask(on_mask), .sw_run(sw_run), .sw_mask(sw_mask), .discharge_required(dis_req),
    .up_slot(up_slot), .dn_slot(dn_slot), .direct_en(direct), .up_delay(up_delay),
    .dn_delay(dn_delay), .up_tmo_code(up_tc), .dn_tmo_code(dn_tc), .rail_good(rail_good),
    .rail_discharged(rail_dis), .bp_enable(bp_en), .bp_position(bp_pos), .rail_en(rail_en),
    .seq_status(st), .pos_count(pos), .bp_match(bp_match), .up_fault(up_fault),
    .down_fault(down_fault)
  );

  always @(negedge clk) begin
    for (int k = 0; k < NCH; k++) begin
      if (rail_en[k] && !en_prev[k]) rise[k] = cyc;
      if (!rail_en[k] && en_prev[k]) fall[k] = cyc;
    end
    en_prev = rail_en;
    if (st == 2'd1 && pos < 16 && pos_arr[pos] < 0) pos_arr[pos] = cyc;
    if (st == 2'd2 && st_prev != 2'd2) dn_start = int'(pos);
    st_prev = st;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    for (int k = 0; k < NCH; k++) begin rise[k] = -1; fall[k] = -1; end
    for (int p = 0; p < 16; p++) pos_arr[p] = -1;
    dn_start = -1;
  endtask

  task automatic wait_st(input logic [1:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (st == s) break;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(st == 2'd0, "R2 reset status", st, 0);
    chk(pos == 0, "R2 reset count", pos, 0);
    chk(rail_en == '0 && !up_fault && !down_fault && !bp_match, "R2 reset outputs", rail_en, 0);
  endtask

  task automatic t_qual();
    on_mask = 1; on_active_low = 1; on_pin = 1; sw_mask = 0;
    repeat (8) @(negedge clk);
    chk(st == 2'd0, "R1 active-low pin high stays off", st, 0);
    sw_mask = 1; sw_run = 0; on_pin = 0;
    repeat (8) @(negedge clk);
    chk(st == 2'd0, "R1 sw bit required and low", st, 0);
    clear_rec();
    sw_run = 1;
    wait_st(2'd1, 10);
    chk(st == 2'd1 && pos == 1, "R1/R2 start at count 1", pos, 1);
  endtask

  task automatic t_up();
    wait_st(2'd3, 200);
    chk(st == 2'd3, "R12 reaches on", st, 3);
    chk(pos == 4, "R12 count kept at top slot", pos, 4);
    chk(pos_arr[2] - pos_arr[1] == 2, "R3 advance after slot done", pos_arr[2] - pos_arr[1], 2);
    chk(pos_arr[3] - pos_arr[2] == 7, "R3 waits for slowest rail", pos_arr[3] - pos_arr[2], 7);
    chk(rise[1] - pos_arr[2] == 4, "R4 delay 3", rise[1] - pos_arr[2], 4);
    chk(rise[2] - pos_arr[2] == 6, "R4 delay 5", rise[2] - pos_arr[2], 6);
    chk(rise[3] - pos_arr[4] == 3, "R4 delay 2", rise[3] - pos_arr[4], 3);
    chk(rail_en[3:0] == 4'hF, "R3 all sequenced on", rail_en[3:0], 15);
  endtask

  task automatic t_direct();
    direct[4] = 1;
    @(negedge clk);
    @(negedge clk);
    chk(rail_en[4] == 1'b1, "R5 direct on", rail_en[4], 1);
    chk(rail_en[5] == 1'b0, "R5 direct off", rail_en[5], 0);
    direct[4] = 0;
    @(negedge clk);
    @(negedge clk);
    chk(rail_en[4] == 1'b0, "R5 direct released", rail_en[4], 0);
  endtask

  task automatic t_down();
    clear_rec();
    sw_run = 0;
    wait_st(2'd0, 200);
    chk(st == 2'd0 && pos == 0, "R7 down done", pos, 0);
    chk(dn_start == 5, "R7 starts at top down slot", dn_start, 5);
    chk(fall[3] < fall[1] && fall[1] < fall[2] && fall[2] < fall[0], "R7 down order", fall[0], fall[3]);
    chk(rail_en[3:0] == 4'h0, "R7 all off", rail_en[3:0], 0);
  endtask

  task automatic t_discharge();
    dis_req = 1; dis_kill[1] = 1; dis_kill[5] = 1;
    sw_run = 1;
    repeat (10) @(negedge clk);
    chk(st == 2'd0, "R6 blocked by charged rail", st, 0);
    dis_kill[1] = 0;
    wait_st(2'd1, 10);
    chk(st == 2'd1, "R6 unsequenced rail ignored", st, 1);
    wait_st(2'd3, 200);
    sw_run = 0;
    wait_st(2'd0, 200);
    dis_req = 0; dis_kill = '0;
  endtask

  task automatic t_bp();
    bp_en = 1; bp_pos = 2;
    sw_run = 1;
    wait_st(2'd1, 10);
    repeat (30) @(negedge clk);
    chk(st == 2'd1 && pos == 2, "R9 count held at breakpoint", pos, 2);
    chk(bp_match == 1'b1, "R9 match flag", bp_match, 1);
    chk(rail_en[2:0] == 3'h7, "R9 slot rails still act", rail_en[2:0], 7);
    bp_en = 0;
    wait_st(2'd3, 200);
    chk(st == 2'd3, "R9 release continues", st, 3);
    chk(bp_match == 1'b0, "R9 match clears", bp_match, 0);
    sw_run = 0;
    wait_st(2'd0, 200);
  endtask

  task automatic t_abort();
    clear_rec();
    bp_en = 1; bp_pos = 2;
    sw_run = 1;
    wait_st(2'd1, 10);
    repeat (20) @(negedge clk);
    sw_run = 0;
    wait_st(2'd0, 200);
    chk(dn_start == 2, "R8 down from current count", dn_start, 2);
    chk(st == 2'd0 && rail_en[3:0] == 0, "R8 abort ends off", rail_en[3:0], 0);
    bp_en = 0;
  endtask

  task automatic t_upto();
    int e;
    good_kill[3] = 1; utc[3] = 3'd1;
    sw_run = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rail_en[3]) break;
    end
    e = cyc;
    while (cyc < e + 2) @(negedge clk);
    chk(up_fault == 1'b0, "R10 no fault inside window", up_fault, 0);
    while (cyc < e + 6) @(negedge clk);
    chk(up_fault == 1'b1, "R10 fault after 4 ticks", up_fault, 1);
    chk(st == 2'd1 && pos == 4, "R10 count holds on fault", pos, 4);
    sw_run = 0;
    wait_st(2'd0, 200);
    chk(up_fault == 1'b1, "R10 fault sticky", up_fault, 1);
    good_kill = '0; utc[3] = 3'd0;
    sw_run = 1;
    wait_st(2'd1, 10);
    chk(up_fault == 1'b0, "R10 cleared at next start", up_fault, 0);
    wait_st(2'd3, 200);
  endtask

  task automatic t_dnto();
    int f;
    dis_kill[0] = 1; dtc[0] = 3'd1;
    sw_run = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (st == 2'd2 && !rail_en[0]) break;
    end
    f = cyc;
    while (cyc < f + 4) @(negedge clk);
    chk(down_fault == 1'b0, "R11 no fault inside window", down_fault, 0);
    while (cyc < f + 12) @(negedge clk);
    chk(down_fault == 1'b1, "R11 fault after 8 ticks", down_fault, 1);
    chk(st == 2'd2, "R11 down stalls", st, 2);
    dis_kill = '0;
    wait_st(2'd0, 200);
    chk(st == 2'd0 && down_fault, "R11 finishes, fault sticky", down_fault, 1);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      upp[i] = 0; dnp[i] = 0; udl[i] = 0; ddl[i] = 1; utc[i] = 0; dtc[i] = 0;
    end
    upp[0] = 1; upp[1] = 2; upp[2] = 2; upp[3] = 4;
    dnp[0] = 1; dnp[1] = 3; dnp[2] = 2; dnp[3] = 5;
    udl[1] = 3; udl[2] = 5; udl[3] = 2;
    clear_rec();
    t_reset();
    t_qual();
    t_up();
    t_direct();
    t_down();
    t_discharge();
    t_bp();
    t_abort();
    t_upto();
    t_dnto();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule